// File: doc/BRIEF.md
# Protected Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash. It takes clean, single-clock write events, each with an address and a data byte. It recognises the guarded multi-write sequences that alter the array or switch the identification view. Each guarded sequence opens with a two-write key: AAh written to the primary key address 5555h, then 55h written to the secondary key address 2AAAh. The block raises a one-clock start pulse for three operations: byte program, sector erase and chip erase. The pulse carries the operation code, the target address, the data byte and the 4 KiB sector number.

The decoder also keeps an identification-mode flag. While the flag is set, a combinational read port returns the manufacturer and device codes. Any write that breaks an expected step sends the decoder back to plain read mode. While the external `busy` input reports that an internal program or erase is running, every write is dropped, the exit command included.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `start` is low, `start_op` is 0, `id_mode` is low and `id_data` reads FFh.
- R2: Byte program is AAh@5555h, then 55h@2AAAh, then A0h@5555h, then a fourth write of any address and data. In the clock after the fourth write, `start` is high for one cycle with `start_op`=1 and with `start_addr` and `start_data` equal to that fourth write.
- R3: The two-write key, then 80h@5555h, AAh@5555h, 55h@2AAAh, then a sixth write of 30h at any address gives a pulse with `start_op`=2. `start_addr` is that address and `sector` is that address shifted right by 12.
- R4: The same five-write erase lead-in followed by 10h@5555h gives a pulse with `start_op`=3 and `start_addr` = 5555h.
- R5: The two-write key, then 90h@5555h, sets `id_mode`. While `id_mode` is set, `id_data` is BFh for `rd_addr`=0, DEV_CODE for `rd_addr`=1 and FFh for any other address. While `id_mode` is clear, `id_data` is FFh.
- R6: The two-write key, then F0h@5555h, clears `id_mode`.
- R7: A single write of F0h at any address clears `id_mode`. The exception is the data step of a byte program, where F0h is program data and `id_mode` is unchanged.
- R8: A write that does not match the expected next step returns the decoder to read mode. Writes that would have completed the broken sequence give no pulse, and a new key sent right after the abort is accepted.
- R9: While `busy` is high, writes change no state: they give no pulse, leave `id_mode` unchanged and leave a partly entered sequence at the step it had reached.
- R10: Only address bits 14:0 are compared with the key addresses, so AAh written at 15555h opens a sequence.
- R11: `start` is never high in two consecutive cycles, and `start_op` is 0 whenever `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-clock write event |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Internal program or erase in progress |
| rd_addr | input | ADDR_W | Address for identification reads |
| start | output | 1 | One-clock operation start pulse |
| start_op | output | 2 | 0 idle, 1 program, 2 sector erase, 3 chip erase |
| start_addr | output | ADDR_W | Target address of the operation |
| start_data | output | 8 | Program data byte |
| sector | output | ADDR_W-12 | Sector number of start_addr |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 8 | Identification read data |

## Verification
A wrong sequence step is not visible when it happens. It only shows at the write that should end a sequence: either a start pulse goes missing, or an extra pulse appears one clock after a write that ought to have been dropped. The bench therefore runs every broken sequence through to the write that would complete it, and checks that no pulse follows. A wrong identification flag shows on `id_data` in the same cycle, because the read path is combinational. The flag is checked after each entry, each exit and each write made while `busy` is high.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam int KEY_W = 15;
    localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_BYTE_A = 8'hAA;
    localparam logic [7:0] KEY_BYTE_B = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_ID_IN  = 8'h90;
    localparam logic [7:0] CMD_ID_OUT = 8'hF0;
    localparam logic [7:0] MFR_CODE   = 8'hBF;
    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_READ,
        ST_KEY1,
        ST_KEY2,
        ST_PDATA,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3
    } seq_e;

    typedef struct packed {
        logic fire;
        op_e  op;
        logic id_set;
        logic id_clr;
    } seq_act_t;

    function automatic logic key_hit(input logic [KEY_W-1:0] a,
                                     input logic [KEY_W-1:0] k);
        return a == k;
    endfunction

endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             busy,
    input  logic [KEY_W-1:0] key_addr,
    input  logic [7:0]       wr_data,
    output seq_act_t         act,
    output logic             id_mode
);

    seq_e st_q, st_d;
    logic id_q;
    logic accept;
    logic at_a, at_b;

    assign accept = wr_en && !busy;
    assign at_a   = key_hit(key_addr, KEY_ADDR_A);
    assign at_b   = key_hit(key_addr, KEY_ADDR_B);

    always_comb begin
        st_d = st_q;
        act  = '0;
        if (accept) begin
            st_d = ST_READ;
            unique case (st_q)
                ST_READ:  if (at_a && wr_data == KEY_BYTE_A) st_d = ST_KEY1;
                ST_KEY1:  if (at_b && wr_data == KEY_BYTE_B) st_d = ST_KEY2;
                ST_KEY2: begin
                    if (at_a) begin
                        if (wr_data == CMD_PROG)       st_d = ST_PDATA;
                        else if (wr_data == CMD_ERASE) st_d = ST_ERS1;
                        else if (wr_data == CMD_ID_IN) act.id_set = 1'b1;
                    end
                end
                ST_PDATA: begin
                    act.fire = 1'b1;
                    act.op   = OP_PROG;
                end
                ST_ERS1:  if (at_a && wr_data == KEY_BYTE_A) st_d = ST_ERS2;
                ST_ERS2:  if (at_b && wr_data == KEY_BYTE_B) st_d = ST_ERS3;
                ST_ERS3: begin
                    if (wr_data == CMD_SECT) begin
                        act.fire = 1'b1;
                        act.op   = OP_SECT;
                    end else if (at_a && wr_data == CMD_CHIP) begin
                        act.fire = 1'b1;
                        act.op   = OP_CHIP;
                    end
                end
                default: st_d = ST_READ;
            endcase
            if (st_q != ST_PDATA && wr_data == CMD_ID_OUT)
                act.id_clr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_READ;
            id_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (act.id_clr)      id_q <= 1'b0;
            else if (act.id_set) id_q <= 1'b1;
        end
    end

    assign id_mode = id_q;

endmodule

// File: rtl/nor_issue.sv
module nor_issue
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_act_t          act,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              start,
    output op_e               start_op,
    output logic [ADDR_W-1:0] start_addr,
    output logic [7:0]        start_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start    <= 1'b0;
            start_op <= OP_IDLE;
        end else begin
            start    <= act.fire;
            start_op <= act.fire ? act.op : OP_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr <= '0;
            start_data <= '0;
        end else if (act.fire) begin
            start_addr <= wr_addr;
            start_data <= wr_data;
        end
    end

endmodule

// File: rtl/nor_id_read.sv
module nor_id_read
    import nor_cmd_pkg::*;
#(
    parameter int         ADDR_W   = 17,
    parameter logic [7:0] DEV_CODE = 8'hB5
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        id_data
);

    always_comb begin
        id_data = BLANK_BYTE;
        if (id_mode) begin
            if (rd_addr == ADDR_W'(0))      id_data = MFR_CODE;
            else if (rd_addr == ADDR_W'(1)) id_data = DEV_CODE;
        end
    end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int         ADDR_W     = 17,
    parameter int         SECT_SHIFT = 12,
    parameter logic [7:0] DEV_CODE   = 8'hB5,
    localparam int        SECT_W     = ADDR_W - SECT_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              start,
    output logic [1:0]        start_op,
    output logic [ADDR_W-1:0] start_addr,
    output logic [7:0]        start_data,
    output logic [SECT_W-1:0] sector,
    output logic              id_mode,
    output logic [7:0]        id_data
);

    seq_act_t act;
    op_e      op_q;

    nor_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .busy     (busy),
        .key_addr (wr_addr[KEY_W-1:0]),
        .wr_data  (wr_data),
        .act      (act),
        .id_mode  (id_mode)
    );

    nor_issue #(.ADDR_W(ADDR_W)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .start      (start),
        .start_op   (op_q),
        .start_addr (start_addr),
        .start_data (start_data)
    );

    nor_id_read #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_id (
        .id_mode (id_mode),
        .rd_addr (rd_addr),
        .id_data (id_data)
    );

    assign start_op = op_q;
    assign sector   = start_addr[ADDR_W-1:SECT_SHIFT];

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              busy,
    input logic              start,
    input logic [1:0]        start_op,
    input logic [ADDR_W-1:0] start_addr,
    input logic              id_mode
);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    assert_idle_op_R11: assert property (@(posedge clk) disable iff (rst)
        !start |-> start_op == 2'd0);

    assert_busy_no_start_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> !start);

    assert_busy_id_hold_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(id_mode));

    assert_id_entry_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(id_mode) |-> $past(wr_en && wr_data == 8'h90));

    assert_id_exit_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(id_mode) |-> $past(wr_en && wr_data == 8'hF0));

    assert_chip_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (start && start_op == 2'd3) |-> start_addr[14:0] == 15'h5555);

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .busy       (busy),
    .start      (start),
    .start_op   (start_op),
    .start_addr (start_addr),
    .id_mode    (id_mode)
);

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;

    localparam int ADDR_W = 17;
    localparam int SECT_W = ADDR_W - 12;
    localparam logic [7:0] DEV = 8'hB5;

    typedef struct {
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              busy = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              start;
    logic [1:0]        start_op;
    logic [ADDR_W-1:0] start_addr;
    logic [7:0]        start_data;
    logic [SECT_W-1:0] sector;
    logic              id_mode;
    logic [7:0]        id_data;

    int checks = 0;
    int fails  = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    nor_cmd_decoder #(.ADDR_W(ADDR_W), .DEV_CODE(DEV)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
        .start(start), .start_op(start_op), .start_addr(start_addr),
        .start_data(start_data), .sector(sector), .id_mode(id_mode),
        .id_data(id_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_op(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                             input logic [7:0] d, input string req);
        exp_t e;
        e.op = op; e.addr = a; e.data = d; e.req = req;
        sb.push_back(e);
    endtask

    task automatic key();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
    endtask

    task automatic erase_lead();
        key();
        wr(17'h05555, 8'h80);
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
    endtask

    // monitor: pops the scoreboard whenever a start pulse appears (R2, R3, R4, R11)
    always @(negedge clk) begin
        if (!rst) begin
            if (start) begin
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R8/R9: actual unexpected start op %0d addr %0h expected no start",
                             start_op, start_addr);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.req, " op"},     32'(start_op),   32'(e.op));
                    check({e.req, " addr"},   32'(start_addr), 32'(e.addr));
                    if (e.op == 2'd1) check({e.req, " data"}, 32'(start_data), 32'(e.data));
                    check({e.req, " sector"}, 32'(sector),     32'(e.addr >> 12));
                end
            end else begin
                check("R11 idle op", 32'(start_op), 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 start", 32'(start), 32'd0);
        check("R1 op", 32'(start_op), 32'd0);
        check("R1 id_mode", 32'(id_mode), 32'd0);
        check("R1 id_data", 32'(id_data), 32'hFF);

        // R2 program
        key(); wr(17'h05555, 8'hA0);
        expect_op(2'd1, 17'h0ABCD, 8'h3C, "R2");
        wr(17'h0ABCD, 8'h3C);

        // R3 sector erase, any address
        erase_lead();
        expect_op(2'd2, 17'h1ABCD, 8'h30, "R3");
        wr(17'h1ABCD, 8'h30);

        // R4 chip erase
        erase_lead();
        expect_op(2'd3, 17'h05555, 8'h10, "R4");
        wr(17'h05555, 8'h10);

        // R5 ID entry and reads
        key(); wr(17'h05555, 8'h90);
        check("R5 id_mode", 32'(id_mode), 32'd1);
        rd_addr = 17'd0; #1 check("R5 mfr", 32'(id_data), 32'hBF);
        rd_addr = 17'd1; #1 check("R5 dev", 32'(id_data), 32'(DEV));
        rd_addr = 17'd7; #1 check("R5 other", 32'(id_data), 32'hFF);

        // R7 F0 as program data keeps ID mode
        key(); wr(17'h05555, 8'hA0);
        expect_op(2'd1, 17'h00200, 8'hF0, "R7 prog data");
        wr(17'h00200, 8'hF0);
        check("R7 id kept", 32'(id_mode), 32'd1);

        // R6 exit by keyed F0
        key(); wr(17'h05555, 8'hF0);
        check("R6 id_mode", 32'(id_mode), 32'd0);
        rd_addr = 17'd0; #1 check("R5 off read", 32'(id_data), 32'hFF);

        // R7 single F0 at any address
        key(); wr(17'h05555, 8'h90);
        check("R7 id set", 32'(id_mode), 32'd1);
        wr(17'h13333, 8'hF0);
        check("R7 id_mode", 32'(id_mode), 32'd0);

        // R8 wrong data at third step aborts; follow-on write must not start
        key(); wr(17'h05555, 8'h12);
        wr(17'h00100, 8'h77);
        // R8 abort inside erase lead-in
        key(); wr(17'h05555, 8'h80); wr(17'h05555, 8'hAB);
        wr(17'h02AAA, 8'h55); wr(17'h04000, 8'h30);
        // R8 fresh key after abort accepted
        key(); wr(17'h05555, 8'hA0);
        expect_op(2'd1, 17'h00321, 8'h5A, "R8 recover");
        wr(17'h00321, 8'h5A);

        // R9 busy drops writes
        busy = 1'b1;
        key(); wr(17'h05555, 8'hA0); wr(17'h00400, 8'h11);
        key(); wr(17'h05555, 8'h90);
        check("R9 id unchanged", 32'(id_mode), 32'd0);
        busy = 1'b0;
        key(); wr(17'h05555, 8'h90);
        busy = 1'b1;
        wr(17'h00000, 8'hF0);
        check("R9 exit ignored", 32'(id_mode), 32'd1);
        busy = 1'b0;
        wr(17'h00000, 8'hF0);
        check("R9 exit after busy", 32'(id_mode), 32'd0);
        // R9 partial sequence held across busy writes
        key();
        busy = 1'b1; wr(17'h01234, 8'h99); busy = 1'b0;
        wr(17'h05555, 8'hA0);
        expect_op(2'd1, 17'h00555, 8'h66, "R9 held step");
        wr(17'h00555, 8'h66);

        // R10 upper address bits ignored in key compare
        wr(17'h15555, 8'hAA); wr(17'h12AAA, 8'h55); wr(17'h15555, 8'hA0);
        expect_op(2'd1, 17'h1F000, 8'hC3, "R10");
        wr(17'h1F000, 8'hC3);

        repeat (4) @(negedge clk);
        check("R2 scoreboard drained", 32'(sb.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule